// File: doc/BRIEF.md
# Fractional-N Main Loop Divider

This block divides the VCO clock for the main loop of a fractional-N synthesizer. Each divider cycle normally lasts N VCO clocks. A small accumulator adds a fractional increment at every cycle boundary. When the accumulator wraps, the following cycle lasts N+1 clocks. Over Q cycles the mean ratio is therefore N plus the increment divided by Q, and Q is either 5 or 8. One single-clock pulse per cycle goes to the phase detector.

The block also drives the present accumulator value and a window of fixed width that starts with each pulse. An external compensation current source uses the two together: the value sets the amplitude, and the window sets the duration. A new ratio, increment or modulus is captured on a load strobe. It is applied only at the next cycle boundary, so the output phase never steps in the middle of a cycle. A resynchronization request restarts the divider from a clean state, so that it can be aligned with the reference path when the loop powers up. While the enable input is low, the block is held cleared.

Top module: `fracn_main_div`

## Requirements
- R1: While enabled, `div_pulse` is high for exactly one clock at the end of each divider cycle. A cycle with no pending stretch lasts N clocks, where N is the applied ratio.
- R2: A loaded ratio below MIN_RATIO (default 512) is raised to MIN_RATIO. Ratios up to 65535 are taken as given.
- R3: At each cycle boundary the accumulator adds the increment modulo Q. Q is 5 when `mod5_sel`=1 and 8 when `mod5_sel`=0. `acc_value` shows the result from the clock of the pulse onward.
- R4: A boundary at which the accumulator wraps (sum ≥ Q) makes the next cycle N+1 clocks long.
- R5: With `mod5_sel`=1, a loaded increment of 5, 6 or 7 is reduced by 5 before use.
- R6: A load during a cycle leaves the length of that cycle unchanged. The new settings govern the cycles after the next boundary.
- R7: A boundary at which the modulus selection changes clears the accumulator before the increment is added.
- R8: `comp_window` rises together with `div_pulse` and stays high for exactly WIN_CYCLES clocks (default 128). `acc_value` does not change while the window is high.
- R9: A clock with `resync`=1 clears the cycle counter, the accumulator, the stretch, the pulse and the window, and applies any pending settings. The next pulse follows N clocks later.
- R10: While `enable`=0, `div_pulse`, `comp_window` and `acc_value` stay 0. After `enable` returns to 1, the first pulse comes on the Nth enabled clock.
- R11: After reset, all outputs are 0 and the applied settings are ratio MIN_RATIO, increment 0, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run enable; low holds the divider cleared |
| resync | input | 1 | Restart request for alignment with the reference |
| load | input | 1 | Captures ratio_in, frac_in and mod5_sel |
| ratio_in | input | 16 | Integer division ratio N |
| frac_in | input | 3 | Fractional increment |
| mod5_sel | input | 1 | 1: modulo 5, 0: modulo 8 |
| div_pulse | output | 1 | One-clock pulse per divider cycle |
| acc_value | output | 3 | Present accumulator contents |
| comp_window | output | 1 | Compensation timing window |

## Verification
A wrong accumulator value shows up at the ports in two ways. It appears on `acc_value` in the clock of the next pulse. It also moves the following pulse by one clock, because the stretch decision comes from the same sum. A counter or settings fault shows as a pulse interval that differs from N or N+1, and the bench measures every interval against a model built from the requirements. Faults in the window or in the clearing paths show within one cycle, as a wrong window width or as nonzero outputs while the divider is held.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    localparam int RATIO_W = 16;
    localparam int NF_W    = 3;
    localparam int ACC_W   = 3;
    localparam int Q_W     = ACC_W + 1;
    localparam int MOD5_Q  = 5;
    localparam int MOD8_Q  = 8;

    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
        logic [NF_W-1:0]    nf;
        logic               mod5;
    } div_cfg_t;

    function automatic logic [Q_W-1:0] modulus(input logic mod5);
        return mod5 ? Q_W'(MOD5_Q) : Q_W'(MOD8_Q);
    endfunction

    // Clamp the ratio to its floor and fold the increment into the modulus.
    function automatic div_cfg_t sanitize(input div_cfg_t raw,
                                          input logic [RATIO_W-1:0] floor_ratio);
        div_cfg_t c;
        c = raw;
        if (raw.ratio < floor_ratio)
            c.ratio = floor_ratio;
        if (raw.mod5 && ({1'b0, raw.nf} >= Q_W'(MOD5_Q)))
            c.nf = raw.nf - NF_W'(MOD5_Q);
        return c;
    endfunction

endpackage

// File: rtl/fracn_cfg_regs.sv
module fracn_cfg_regs
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  div_cfg_t           cfg_in,
    input  logic               apply,
    output div_cfg_t           next_cfg,
    output logic [RATIO_W-1:0] active_ratio,
    output logic               active_mod5,
    output logic               mode_change
);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);
    localparam div_cfg_t RESET_CFG = '{ratio: FLOOR, nf: '0, mod5: 1'b0};

    div_cfg_t pending;

    // A load in the same clock as a boundary is applied at once.
    assign next_cfg    = load ? sanitize(cfg_in, FLOOR) : pending;
    assign mode_change = next_cfg.mod5 != active_mod5;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending      <= RESET_CFG;
            active_ratio <= FLOOR;
            active_mod5  <= 1'b0;
        end else begin
            pending <= next_cfg;
            if (apply) begin
                active_ratio <= next_cfg.ratio;
                active_mod5  <= next_cfg.mod5;
            end
        end
    end
endmodule

// File: rtl/fracn_accum.sv
module fracn_accum
    import fracn_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic             restart,
    input  logic [NF_W-1:0]  nf,
    input  logic             mod5,
    output logic [ACC_W-1:0] acc,
    output logic             stretch
);
    logic [Q_W-1:0] base;
    logic [Q_W-1:0] sum;
    logic [Q_W-1:0] q;
    logic           wrap;

    always_comb begin
        base = restart ? '0 : {1'b0, acc};
        sum  = base + Q_W'(nf);
        q    = modulus(mod5);
        wrap = sum >= q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc     <= '0;
            stretch <= 1'b0;
        end else if (step) begin
            acc     <= wrap ? ACC_W'(sum - q) : ACC_W'(sum);
            stretch <= wrap;
        end
    end
endmodule

// File: rtl/fracn_cycle_counter.sv
module fracn_cycle_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic [CNT_W-1:0] len,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && !clr && (cnt == len - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (run)
            cnt <= tick ? '0 : cnt + CNT_W'(1);
    end
endmodule

// File: rtl/fracn_comp_window.sv
module fracn_comp_window #(
    parameter int WIN_CYCLES = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic win
);
    localparam int W = $clog2(WIN_CYCLES + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            win <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            win <= 1'b1;
            cnt <= '0;
        end else if (win) begin
            if (cnt == W'(WIN_CYCLES - 1))
                win <= 1'b0;
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/fracn_main_div.sv
module fracn_main_div
    import fracn_pkg::*;
#(
    parameter int MIN_RATIO  = 512,
    parameter int WIN_CYCLES = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               resync,
    input  logic               load,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic [NF_W-1:0]    frac_in,
    input  logic               mod5_sel,
    output logic               div_pulse,
    output logic [ACC_W-1:0]   acc_value,
    output logic               comp_window
);
    localparam int CNT_W = RATIO_W + 1;

    div_cfg_t           cfg_in;
    div_cfg_t           next_cfg;
    logic [RATIO_W-1:0] active_ratio;
    logic               active_mod5;
    logic               mode_change;
    logic               halt;
    logic               tick;
    logic               stretch;
    logic [CNT_W-1:0]   cycle_len;
    logic [Q_W-1:0]     q_active;

    assign cfg_in    = '{ratio: ratio_in, nf: frac_in, mod5: mod5_sel};
    assign halt      = !enable || resync;
    assign cycle_len = CNT_W'(active_ratio) + CNT_W'(stretch);
    assign q_active  = modulus(active_mod5);

    fracn_cfg_regs #(.MIN_RATIO(MIN_RATIO)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .cfg_in      (cfg_in),
        .apply       (tick || halt),
        .next_cfg    (next_cfg),
        .active_ratio(active_ratio),
        .active_mod5 (active_mod5),
        .mode_change (mode_change)
    );

    fracn_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (halt),
        .run (enable),
        .len (cycle_len),
        .tick(tick)
    );

    fracn_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (halt),
        .step   (tick),
        .restart(mode_change),
        .nf     (next_cfg.nf),
        .mod5   (next_cfg.mod5),
        .acc    (acc_value),
        .stretch(stretch)
    );

    fracn_comp_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
        .clk  (clk),
        .rst  (rst),
        .clr  (halt),
        .start(tick),
        .win  (comp_window)
    );

    always_ff @(posedge clk) begin
        if (rst || halt)
            div_pulse <= 1'b0;
        else
            div_pulse <= tick;
    end
endmodule

// File: rtl/fracn_main_div_chk.sv
module fracn_main_div_chk
    import fracn_pkg::*;
#(
    parameter int WIN_CYCLES = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             resync,
    input logic             div_pulse,
    input logic             comp_window,
    input logic [ACC_W-1:0] acc_value,
    input logic [Q_W-1:0]   q_now
);
    localparam int RW = $clog2(WIN_CYCLES + 2) + 1;

    logic [RW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)
            run_len <= '0;
        else
            run_len <= comp_window ? run_len + RW'(1) : '0;
    end

    p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        div_pulse |=> !div_pulse);

    p_acc_below_q_r3: assert property (@(posedge clk) disable iff (rst)
        {1'b0, acc_value} < q_now);

    p_window_with_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        div_pulse |-> comp_window);

    p_acc_stable_in_window_r8: assert property (@(posedge clk) disable iff (rst)
        (comp_window && !div_pulse) |-> $stable(acc_value));

    p_window_width_r8: assert property (@(posedge clk) disable iff (rst)
        ($fell(comp_window) && $past(enable) && !$past(resync)) |-> (run_len == RW'(WIN_CYCLES)));

    p_held_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!div_pulse && !comp_window && acc_value == '0));

    p_resync_clear_r9: assert property (@(posedge clk) disable iff (rst)
        resync |=> (!div_pulse && !comp_window && acc_value == '0));
endmodule

bind fracn_main_div fracn_main_div_chk #(.WIN_CYCLES(WIN_CYCLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .resync     (resync),
    .div_pulse  (div_pulse),
    .comp_window(comp_window),
    .acc_value  (acc_value),
    .q_now      (q_active)
);

// File: tb/test_fracn_main_div.sv
module test_fracn_main_div;
    localparam int MINR = 512;
    localparam int WIN  = 128;
    // vector fields: ratio[25:10] nf[9:7] mod5[6] pulses[5:0]
    localparam logic [25:0] VEC [6] = '{
        {16'd520, 3'd0, 1'b0, 6'd3},
        {16'd520, 3'd2, 1'b1, 6'd6},
        {16'd530, 3'd3, 1'b0, 6'd9},
        {16'd515, 3'd7, 1'b1, 6'd6},
        {16'd100, 3'd1, 1'b0, 6'd3},
        {16'd600, 3'd4, 1'b1, 6'd5}
    };

    logic        clk = 1'b0;
    logic        rst, enable, resync, load, mod5_sel;
    logic [15:0] ratio_in;
    logic [2:0]  frac_in;
    logic        div_pulse, comp_window;
    logic [2:0]  acc_value;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fracn_main_div i_fracn_main_div (
        .clk(clk), .rst(rst), .enable(enable), .resync(resync), .load(load),
        .ratio_in(ratio_in), .frac_in(frac_in), .mod5_sel(mod5_sel),
        .div_pulse(div_pulse), .acc_value(acc_value), .comp_window(comp_window)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_pulse(output int k);
        k = 0;
        do begin
            tick();
            k++;
        end while (!div_pulse && k < 70000);
    endtask

    task automatic program_now(input int n, input int nf, input bit m5);
        ratio_in = 16'(n); frac_in = 3'(nf); mod5_sel = m5;
        load = 1'b1; resync = 1'b1;
        tick();
        load = 1'b0; resync = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k, w;
        rst = 1'b1; enable = 1'b0; resync = 1'b0; load = 1'b0;
        ratio_in = '0; frac_in = '0; mod5_sel = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R11: reset state and default settings
        check(!div_pulse && !comp_window && acc_value == 0, "R11", "outputs after reset",
              int'({div_pulse, comp_window, acc_value}), 0);
        enable = 1'b1;
        wait_pulse(k);
        check(k == MINR, "R11", "default interval", k, MINR);
        check(acc_value == 0, "R11", "default accumulator", acc_value, 0);
        // R8: window width starting with the pulse
        check(comp_window == 1'b1, "R8", "window at pulse", comp_window, 1);
        w = 1;
        forever begin
            tick();
            if (!comp_window) break;
            w++;
        end
        check(w == WIN, "R8", "window width", w, WIN);

        // table-driven runs (R1 R2 R3 R4 R5)
        for (int v = 0; v < 6; v++) begin
            int n_raw, nf_raw, n_eff, nf_eff, q, acc_m, str_m, npulse;
            bit m5;
            n_raw  = int'(VEC[v][25:10]);
            nf_raw = int'(VEC[v][9:7]);
            m5     = VEC[v][6];
            npulse = int'(VEC[v][5:0]);
            n_eff  = (n_raw < MINR) ? MINR : n_raw;
            q      = m5 ? 5 : 8;
            nf_eff = (m5 && nf_raw >= 5) ? nf_raw - 5 : nf_raw;
            acc_m = 0; str_m = 0;
            program_now(n_raw, nf_raw, m5);
            for (int c = 0; c < npulse; c++) begin
                int len, s;
                wait_pulse(k);
                len = n_eff + str_m;
                if (n_raw < MINR)
                    check(k == len, "R2", "clamped interval", k, len);
                else if (str_m != 0)
                    check(k == len, "R4", "stretched interval", k, len);
                else
                    check(k == len, "R1", "interval", k, len);
                s = acc_m + nf_eff;
                str_m = (s >= q) ? 1 : 0;
                acc_m = (s >= q) ? s - q : s;
                if (m5 && nf_raw >= 5)
                    check(acc_value == 3'(acc_m), "R5", "folded accumulator", acc_value, acc_m);
                else
                    check(acc_value == 3'(acc_m), "R3", "accumulator", acc_value, acc_m);
            end
        end

        // R6: load mid-cycle waits for the boundary
        program_now(520, 0, 1'b0);
        wait_pulse(k);
        repeat (10) tick();
        ratio_in = 16'd560; load = 1'b1;
        tick();
        load = 1'b0;
        wait_pulse(k);
        check(k == 509, "R6", "cycle during load", k, 509);
        wait_pulse(k);
        check(k == 560, "R6", "cycle after load", k, 560);

        // R7: modulus change clears accumulator
        program_now(520, 3, 1'b0);
        wait_pulse(k);
        wait_pulse(k);
        check(acc_value == 6, "R3", "mod8 accumulator", acc_value, 6);
        repeat (5) tick();
        frac_in = 3'd3; mod5_sel = 1'b1; load = 1'b1;
        tick();
        load = 1'b0;
        wait_pulse(k);
        check(k == 514, "R7", "interval before change", k, 514);
        check(acc_value == 3, "R7", "accumulator after change", acc_value, 3);
        wait_pulse(k);
        check(k == 520, "R7", "interval after change", k, 520);
        check(acc_value == 1, "R7", "mod5 wrap", acc_value, 1);
        wait_pulse(k);
        check(k == 521, "R4", "stretch after wrap", k, 521);

        // R9: resync mid-cycle
        program_now(520, 2, 1'b1);
        wait_pulse(k);
        repeat (49) tick();
        check(comp_window == 1'b1, "R8", "window still open", comp_window, 1);
        resync = 1'b1;
        tick();
        resync = 1'b0;
        check(acc_value == 0 && !comp_window && !div_pulse, "R9", "state after resync",
              int'({div_pulse, comp_window, acc_value}), 0);
        wait_pulse(k);
        check(k == 520, "R9", "first interval after resync", k, 520);
        check(acc_value == 2, "R9", "accumulator after resync", acc_value, 2);

        // R10: disable holds cleared
        program_now(520, 3, 1'b0);
        wait_pulse(k);
        repeat (20) tick();
        enable = 1'b0;
        tick();
        check(acc_value == 0 && !comp_window, "R10", "cleared when disabled",
              int'({comp_window, acc_value}), 0);
        w = 0;
        repeat (30) begin
            tick();
            if (div_pulse || comp_window || acc_value != 0) w++;
        end
        check(w == 0, "R10", "quiet while disabled", w, 0);
        enable = 1'b1;
        wait_pulse(k);
        check(k == 520, "R10", "first interval after enable", k, 520);
        check(acc_value == 3, "R10", "accumulator after enable", acc_value, 3);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule